// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 16-bit timer/counter units. Each unit's value is visible as a low byte and a high byte. An 8-bit mode register picks, for each unit, a pin gate, a count source and one of four counting modes. A control register holds one run bit and one overflow flag per unit. Counting only happens on cycles where the one-cycle `tick` enable is high. In internal-timer operation every tick counts. In external-counter operation a tick counts only when a falling edge has been seen on that unit's synchronized count pin.

There are four modes:

- **Prescaled mode:** a 5-bit prescaler in the low byte drives an 8-bit high-byte counter.
- **Wide mode:** a plain 16-bit counter.
- **Reload mode:** an 8-bit low-byte counter that reloads from the high byte each time it wraps.
- **Split mode:** unit 0 becomes two independent 8-bit timers, and unit 1 stops.

Each overflow flag is set by hardware. It is cleared by an acknowledge strobe from an interrupt controller, or it can be written by software.

Top module: `dual_tmr_ctr`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0x00. This means both units are zero, the mode register selects prescaled mode for both units, and all run bits and flags are clear.
- R2: The register addresses are 0 control, 1 mode, 2 unit-0 low, 3 unit-0 high, 4 unit-1 low and 5 unit-1 high, all read back on `rdata`. The control register bits are 7 = flag 1, 6 = run 1, 5 = flag 0 and 4 = run 0; bits 3..0 read 0. Mode bits 3..0 configure unit 0 and bits 7..4 configure unit 1. Each nibble is {gate, external, mode[1:0]}.
- R3: Mode 0 (prescaled): each count increments low bits 4..0 and leaves low bits 7..5 unchanged. When bits 4..0 wrap from 31 the high byte increments. An overflow occurs when the prescaler wraps while the high byte is 0xFF.
- R4: Mode 1 (wide): {high, low} counts as one 16-bit value and overflows when it wraps from 0xFFFF to 0x0000.
- R5: Mode 2 (reload): the low byte counts. When it wraps from 0xFF it is loaded with the high byte and an overflow occurs. The high byte does not change.
- R6: Mode 3 (split), when set on unit 0: the unit-0 low byte counts under unit 0's run, gate and source, and its wrap sets flag 0. The unit-0 high byte counts every tick while run 1 is set, and its wrap sets flag 1. A wrap of unit 1 then does not set flag 1. A unit 1 set to mode 3 holds its value.
- R7: With external = 0 a unit counts every tick. With external = 1 it counts once per 1-to-0 transition of its count pin after a two-flop synchronizer (three edges of latency), and only when that edge pulse lands on a tick cycle.
- R8: With gate = 1 a unit counts only while its run bit is set and its synchronized gate pin is high. With gate = 0 the run bit alone enables it.
- R9: An overflow sets the unit's flag. An acknowledge strobe clears it, and a control write loads it. A hardware set in the same cycle beats both, and an acknowledge beats a write.
- R10: A write to a count byte takes effect over the count in the same cycle. In modes 0 to 2 a write to either byte of a unit cancels that unit's count in that cycle. In split mode only the written half is cancelled.
- R11: A unit whose run bit is clear does not change, whatever the tick or pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Machine-tick count enable |
| cnt_pin | input | 2 | External count pins, one per unit, asynchronous |
| gate_pin | input | 2 | External gate pins, one per unit, asynchronous |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| ack | input | 2 | Interrupt acknowledge strobes, bit n clears flag n |
| rdata | output | 8 | Read data of the addressed register |
| tf | output | 2 | Overflow flags, bit n for unit n |

## Verification
The assertions check on every cycle that:

- an idle unit holds its value;
- a byte write lands exactly;
- a reload copies the high byte;
- a wide count steps by one;
- unit 1 stays frozen in split mode;
- an overflow always raises its flag, and an acknowledge without a coinciding overflow clears it.

Only the bench scenarios can show the arithmetic of each mode at its wrap points, including:

- the prescaler leaving the low byte's upper bits untouched;
- the routing of the unit-0 high-byte wrap to flag 1 in split mode;
- edge counting through the synchronizer;
- pin gating;
- the priority between a hardware set, an acknowledge and a software write arriving in one cycle.

// File: rtl/tmr_pkg.sv
// Package: shared widths, register addresses and mode encodings for the
// dual timer/counter. Assumes byte-wide registers and a 5-bit prescaler.
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int PRE_W  = 5;
    localparam int ADDR_W = 3;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_MODE = 3'd1,
        A_U0LO = 3'd2,
        A_U0HI = 3'd3,
        A_U1LO = 3'd4,
        A_U1HI = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        M_PRESCALE = 2'd0,
        M_WIDE     = 2'd1,
        M_RELOAD   = 2'd2,
        M_SPLIT    = 2'd3
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   ext;
        tmode_e mode;
    } unit_cfg_t;

    localparam int CB_TF1 = 7;
    localparam int CB_TR1 = 6;
    localparam int CB_TF0 = 5;
    localparam int CB_TR0 = 4;
endpackage

// File: rtl/tmr_pin_sync.sv
// Pin synchronizer: a chain of STAGES flops brings an asynchronous pin
// into the clock domain. FALL_OUT=1 gives a one-cycle pulse on a
// synchronized 1-to-0 transition; FALL_OUT=0 gives the synchronized level.
// Assumes pins idle high, so the chain resets to ones.
module tmr_pin_sync #(
    parameter int STAGES   = 2,
    parameter bit FALL_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic q
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[CHAIN_W-2:0], pin_in};
    end

    generate
        if (FALL_OUT) begin : g_fall
            assign q = chain[STAGES] & ~chain[STAGES-1];
        end else begin : g_level
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tmr_unit.sv
// One 16-bit timer/counter unit made of a low and a high byte. It takes
// count pulses that have already been qualified and applies the selected
// mode. IS_PRIMARY=1 enables the split mode with two 8-bit halves;
// IS_PRIMARY=0 freezes the unit in that mode. Byte writes override counting.
module tmr_unit
    import tmr_pkg::*;
#(
    parameter bit IS_PRIMARY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmode_e            mode,
    input  logic              cnt_lo,
    input  logic              cnt_hi,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              ovf_main,
    output logic              ovf_split
);
    localparam int W2 = 2 * BYTE_W;
    localparam logic [BYTE_W-1:0] B_ONE = BYTE_W'(1);
    localparam logic [PRE_W-1:0]  P_ONE = PRE_W'(1);
    localparam logic [W2-1:0]     D_ONE = W2'(1);

    logic [BYTE_W-1:0] lo_n, hi_n;
    logic              split, frozen, any_wr;

    // Next-state and overflow computation for the selected mode.
    always_comb begin
        lo_n      = lo;
        hi_n      = hi;
        ovf_main  = 1'b0;
        ovf_split = 1'b0;
        split     = (mode == M_SPLIT);
        frozen    = split && !IS_PRIMARY;
        any_wr    = wr_lo || wr_hi;
        if (!frozen) begin
            if (split) begin
                if (cnt_lo && !wr_lo) begin
                    lo_n     = lo + B_ONE;
                    ovf_main = &lo;
                end
                if (cnt_hi && !wr_hi) begin
                    hi_n      = hi + B_ONE;
                    ovf_split = &hi;
                end
            end else if (cnt_lo && !any_wr) begin
                case (mode)
                    M_PRESCALE: begin
                        lo_n = {lo[BYTE_W-1:PRE_W], lo[PRE_W-1:0] + P_ONE};
                        if (&lo[PRE_W-1:0]) hi_n = hi + B_ONE;
                        ovf_main = (&lo[PRE_W-1:0]) && (&hi);
                    end
                    M_WIDE: begin
                        {hi_n, lo_n} = {hi, lo} + D_ONE;
                        ovf_main     = &{hi, lo};
                    end
                    default: begin
                        if (&lo) begin
                            lo_n     = hi;
                            ovf_main = 1'b1;
                        end else begin
                            lo_n = lo + B_ONE;
                        end
                    end
                endcase
            end
        end
        if (wr_lo) lo_n = wdata;
        if (wr_hi) hi_n = wdata;
    end

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= lo_n;
            hi <= hi_n;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_lo && !cnt_hi && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi))); // R11
    AST_WRITE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo == $past(wdata))); // R10
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RELOAD && cnt_lo && !wr_lo && !wr_hi && lo == '1)
        |=> (lo == $past(hi) && $stable(hi))); // R5
    AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_WIDE && cnt_lo && !wr_lo && !wr_hi)
        |=> ({hi, lo} == $past({hi, lo}) + D_ONE)); // R4

    generate
        if (!IS_PRIMARY) begin : g_frozen_chk
            AST_SPLIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == M_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi))); // R6
        end
    endgenerate
endmodule

// File: rtl/dual_tmr_ctr.sv
// Dual timer/counter top level. It holds the control and mode registers,
// synchronizes the count and gate pins, qualifies the count pulses for
// each unit, routes overflows to the flags and muxes register reads.
// Assumes a single synchronous clock, with ticks and strobes one cycle wide.
module dual_tmr_ctr
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        gate_pin,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              we,
    input  logic [1:0]        ack,
    output logic [BYTE_W-1:0] rdata,
    output logic [1:0]        tf
);
    localparam int NUNITS = 2;

    logic [NUNITS-1:0] cnt_fall, gate_lvl, tr, run, src, cnt;
    logic [BYTE_W-1:0] mode_q;
    unit_cfg_t         cfg [NUNITS];
    logic [BYTE_W-1:0] lo [NUNITS];
    logic [BYTE_W-1:0] hi [NUNITS];
    logic [NUNITS-1:0] ovf_main, ovf_split, set_tf;
    logic              wr_ctrl, wr_mode, split0;

    assign cfg[0] = mode_q[3:0];
    assign cfg[1] = mode_q[7:4];

    generate
        for (genvar u = 0; u < NUNITS; u++) begin : g_pins
            tmr_pin_sync #(.STAGES(SYNC_STAGES), .FALL_OUT(1'b1)) u_cnt_sync (
                .clk(clk), .rst_n(rst_n), .pin_in(cnt_pin[u]), .q(cnt_fall[u]));
            tmr_pin_sync #(.STAGES(SYNC_STAGES), .FALL_OUT(1'b0)) u_gate_sync (
                .clk(clk), .rst_n(rst_n), .pin_in(gate_pin[u]), .q(gate_lvl[u]));
            // Qualify counting: run bit, optional pin gate, tick or pin-edge source.
            assign run[u] = tr[u] & (~cfg[u].gate | gate_lvl[u]);
            assign src[u] = cfg[u].ext ? cnt_fall[u] : 1'b1;
            assign cnt[u] = tick & run[u] & src[u];
        end
    endgenerate

    assign wr_ctrl = we && (addr == A_CTRL);
    assign wr_mode = we && (addr == A_MODE);
    assign split0  = (cfg[0].mode == M_SPLIT);

    tmr_unit #(.IS_PRIMARY(1'b1)) u_unit0 (
        .clk(clk), .rst_n(rst_n), .mode(cfg[0].mode),
        .cnt_lo(cnt[0]), .cnt_hi(tick & tr[1]),
        .wr_lo(we && addr == A_U0LO), .wr_hi(we && addr == A_U0HI),
        .wdata(wdata), .lo(lo[0]), .hi(hi[0]),
        .ovf_main(ovf_main[0]), .ovf_split(ovf_split[0]));

    tmr_unit #(.IS_PRIMARY(1'b0)) u_unit1 (
        .clk(clk), .rst_n(rst_n), .mode(cfg[1].mode),
        .cnt_lo(cnt[1]), .cnt_hi(1'b0),
        .wr_lo(we && addr == A_U1LO), .wr_hi(we && addr == A_U1HI),
        .wdata(wdata), .lo(lo[1]), .hi(hi[1]),
        .ovf_main(ovf_main[1]), .ovf_split(ovf_split[1]));

    // Flag set sources: in split mode unit 0's high half owns flag 1.
    assign set_tf[0] = ovf_main[0];
    assign set_tf[1] = split0 ? ovf_split[0] : (ovf_main[1] | ovf_split[1]);

    // Control register: run bits from software; flags with set > ack > write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr <= '0;
            tf <= '0;
        end else begin
            if (wr_ctrl) begin
                tr[0] <= wdata[CB_TR0];
                tr[1] <= wdata[CB_TR1];
            end
            for (int u = 0; u < NUNITS; u++) begin
                if (set_tf[u])    tf[u] <= 1'b1;
                else if (ack[u])  tf[u] <= 1'b0;
                else if (wr_ctrl) tf[u] <= (u == 0) ? wdata[CB_TF0] : wdata[CB_TF1];
            end
        end
    end

    // Mode register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= wdata;
    end

    // Read data multiplexer.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {tf[1], tr[1], tf[0], tr[0], 4'b0000};
            A_MODE:  rdata = mode_q;
            A_U0LO:  rdata = lo[0];
            A_U0HI:  rdata = hi[0];
            A_U1LO:  rdata = lo[1];
            A_U1HI:  rdata = hi[1];
            default: rdata = '0;
        endcase
    end

    AST_TF0_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_main[0] |=> tf[0]); // R9
    AST_TF1_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_tf[1] |=> tf[1]); // R9
    AST_TF0_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[0] && !ovf_main[0]) |=> !tf[0]); // R9
    AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTRL) |-> (rdata[3:0] == 4'b0000)); // R2
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tr[0] && !split0 && !we) |=> ($stable(lo[0]) && $stable(hi[0]))); // R11
endmodule

// File: tb/dual_tmr_ctr_test.sv
module dual_tmr_ctr_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b11;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic       we = 1'b0;
    logic [1:0] ack = 2'b00;
    logic [7:0] rdata;
    logic [1:0] tf;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [2:0] AC = 3'd0, AM = 3'd1, L0 = 3'd2, H0 = 3'd3, L1 = 3'd4, H1 = 3'd5;

    dual_tmr_ctr uut (.clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .addr(addr), .wdata(wdata), .we(we), .ack(ack),
        .rdata(rdata), .tf(tf));

    always #2 clk = ~clk;

    typedef struct packed {
        logic [7:0] md;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] n;
        logic [7:0] ehi;
        logic [7:0] elo;
        logic [7:0] ectl;
    } vec_t;

    // Unit 0 timer-mode vectors: mode, preload hi/lo, ticks, expected hi/lo/ctrl.
    localparam vec_t VECS [8] = '{
        '{8'h01, 8'h00, 8'h00, 8'd5,  8'h00, 8'h05, 8'h10}, // R4 plain count
        '{8'h01, 8'h12, 8'hFE, 8'd3,  8'h13, 8'h01, 8'h10}, // R4 carry into high byte
        '{8'h01, 8'hFF, 8'hFE, 8'd3,  8'h00, 8'h01, 8'h30}, // R4 wrap sets flag 0
        '{8'h00, 8'h00, 8'h1E, 8'd3,  8'h01, 8'h01, 8'h10}, // R3 prescaler carry
        '{8'h00, 8'hFF, 8'hFF, 8'd1,  8'h00, 8'hE0, 8'h30}, // R3 overflow, bits 7..5 kept
        '{8'h02, 8'h80, 8'hFE, 8'd3,  8'h80, 8'h81, 8'h30}, // R5 reload from high byte
        '{8'h02, 8'h00, 8'h00, 8'd10, 8'h00, 8'h0A, 8'h10}, // R5 count without reload
        '{8'h03, 8'h10, 8'hFF, 8'd1,  8'h10, 8'h00, 8'h30}  // R6 split low half wraps
    };

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk); addr = a; #1;
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, a, rdata, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        fails++;
        $display("FAIL all watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 6; a++) chk("R1", 3'(a), 8'h00);

        // R2 register map and readback
        wr(L1, 8'hA5); chk("R2", L1, 8'hA5);
        wr(H1, 8'h5A); chk("R2", H1, 8'h5A);
        wr(AM, 8'hC3); chk("R2", AM, 8'hC3);
        wr(AC, 8'hFF); chk("R2", AC, 8'hF0);
        wr(AC, 8'h00); chk("R2", AC, 8'h00);

        // Vector table walk over the counting modes of unit 0
        foreach (VECS[i]) begin
            wr(AM, VECS[i].md);
            wr(H0, VECS[i].hi);
            wr(L0, VECS[i].lo);
            wr(AC, 8'h10);
            pulse_tick(int'(VECS[i].n));
            chk("R3/R4/R5/R6 vec", H0, VECS[i].ehi);
            chk("R3/R4/R5/R6 vec", L0, VECS[i].elo);
            chk("R9 vec flag", AC, VECS[i].ectl);
        end

        // R11 run bit clear: no counting
        wr(AC, 8'h00); wr(AM, 8'h01); wr(H0, 8'h00); wr(L0, 8'h07);
        pulse_tick(4);
        chk("R11", L0, 8'h07);

        // R6 split: high half runs on run 1 and sets flag 1, unit 1 frozen
        wr(AM, 8'h33); wr(L1, 8'h77); wr(H0, 8'hFF); wr(L0, 8'h05);
        wr(AC, 8'h50);
        pulse_tick(1);
        chk("R6", L0, 8'h06);
        chk("R6", H0, 8'h00);
        chk("R6", L1, 8'h77);
        chk("R6", AC, 8'hD0);
        // R6 unit 1 wrap does not raise flag 1 while unit 0 is split
        wr(AM, 8'h13); wr(AC, 8'h00); wr(H1, 8'hFF); wr(L1, 8'hFF); wr(H0, 8'h00);
        wr(AC, 8'h40);
        pulse_tick(1);
        chk("R6", L1, 8'h00);
        chk("R6", H0, 8'h01);
        chk("R6", AC, 8'h40);

        // R7 external counting on falling edges while tick is held high
        wr(AC, 8'h00); wr(AM, 8'h05); wr(H0, 8'h00); wr(L0, 8'h00);
        wr(AC, 8'h10);
        @(negedge clk); tick = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); cnt_pin[0] = 1'b0; idle(4);
            cnt_pin[0] = 1'b1; idle(4);
        end
        idle(4);
        tick = 1'b0;
        chk("R7", L0, 8'h03);
        // R7 edges without a tick are not counted
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); cnt_pin[0] = 1'b0; idle(4);
            cnt_pin[0] = 1'b1; idle(4);
        end
        idle(4);
        chk("R7", L0, 8'h03);

        // R8 gating by the pin
        gate_pin[0] = 1'b0;
        wr(AC, 8'h00); wr(AM, 8'h09); wr(L0, 8'h00); wr(H0, 8'h00);
        wr(AC, 8'h10);
        pulse_tick(4);
        chk("R8", L0, 8'h00);
        gate_pin[0] = 1'b1; idle(4);
        pulse_tick(4);
        chk("R8", L0, 8'h04);

        // R9 flags: hardware set, acknowledge, software write, priority
        wr(AC, 8'h00); wr(AM, 8'h01); wr(H0, 8'hFF); wr(L0, 8'hFF);
        wr(AC, 8'h10);
        pulse_tick(1);
        chk("R9", AC, 8'h30);
        @(negedge clk); ack = 2'b01;
        @(negedge clk); ack = 2'b00;
        chk("R9", AC, 8'h10);
        wr(AC, 8'h20); chk("R9", AC, 8'h20);
        wr(H0, 8'hFF); wr(L0, 8'hFF); wr(AC, 8'h10);
        @(negedge clk); tick = 1'b1; ack = 2'b01; addr = AC; wdata = 8'h10; we = 1'b1;
        @(negedge clk); tick = 1'b0; ack = 2'b00; we = 1'b0;
        chk("R9", AC, 8'h30);
        wr(AM, 8'h10); wr(AC, 8'h00); wr(H1, 8'hFF); wr(L1, 8'hFF);
        wr(AC, 8'h40);
        pulse_tick(1);
        chk("R9", AC, 8'hC0);
        @(negedge clk); ack = 2'b10;
        @(negedge clk); ack = 2'b00;
        chk("R9", AC, 8'h40);

        // R10 write beats count in the same cycle
        wr(AC, 8'h00); wr(AM, 8'h01); wr(H0, 8'h00); wr(L0, 8'h00);
        wr(AC, 8'h10);
        @(negedge clk); tick = 1'b1; addr = L0; wdata = 8'h40; we = 1'b1;
        @(negedge clk); tick = 1'b0; we = 1'b0;
        chk("R10", L0, 8'h40);
        chk("R10", H0, 8'h00);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule